// File: doc/BRIEF.md
# Condition Register Logic Unit

This block owns a 32-bit condition register split into eight 4-bit fields and performs every operation that reads or modifies it. A compare of two operands, or of an operand against a 16-bit immediate, produces a four-flag summary: less-than, greater-than, equal, and a copy of the caller's summary-overflow flag. That summary is written into one chosen field. Single-bit boolean operations combine two register bits into a third. A field can be copied onto another field. A general-register value can be merged into the register nibble by nibble under an 8-bit mask. The whole register can also be read out.

Fields and bits use big-endian numbering. Field f covers physical bits 31-4f down to 28-4f, so field 0 is the most significant nibble. Bit index n sits at physical position 31-n. The masked move is the exception: it counts its nibbles from the least significant end. One operation is applied per clock, selected by a 4-bit operation code, and its effect becomes visible after that clock edge.

Top module: `crl_unit`

## Requirements
- R1: While reset (`rstN` low) is applied, and after it is released, both `crOut` and `readData` are zero until an operation changes them.
- R2: Opcode 1 compares `srcA` and `srcB` as signed numbers. It writes a nibble into field `dstField` (bits 31-4f..28-4f) with less-than at weight 8, greater-than at weight 4 and equal at weight 2, and leaves the other fields unchanged. Exactly one of these three flags is set.
- R3: Opcode 2 does the same compare as R2 but treats both operands as unsigned.
- R4: Opcode 3 compares `srcA` signed against `imm16` sign-extended to 32 bits. Opcode 4 compares `srcA` unsigned against `imm16` zero-extended. Both write the result into `dstField` in the R2 format.
- R5: Every compare copies `sumOvf` into the weight-1 bit of the written field.
- R6: Opcodes 8 to 15 read bits `bitA` and `bitB` and write bit `bitT`, where bit n is physical position 31-n. The functions are: 8 AND, 9 OR, 10 NAND, 11 XOR, 12 NOR, 13 equivalence, 14 A AND NOT B, 15 A OR NOT B. No other bit changes.
- R7: Opcode 5 copies field `srcField` onto field `dstField` using the same big-endian field positions. All other fields are kept. A copy of a field onto itself changes nothing.
- R8: Opcode 6 takes nibble i (bits 4i+3..4i) from `srcA` when `fieldMask[i]` is 1 and keeps the old nibble otherwise.
- R9: Opcode 7 loads `readData` with the register value held before that edge and leaves the register unchanged. `readData` keeps its value through all other opcodes.
- R10: Opcode 0 changes neither `crOut` nor `readData`, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| opCode | input | 4 | Operation select (see requirements) |
| srcA | input | 32 | First operand; source for the masked move |
| srcB | input | 32 | Second operand for register compares |
| imm16 | input | 16 | Immediate operand for the immediate compares |
| dstField | input | 3 | Field written by compares and copies |
| srcField | input | 3 | Field read by a copy |
| bitA | input | 5 | First bit read by a boolean op |
| bitB | input | 5 | Second bit read by a boolean op |
| bitT | input | 5 | Bit written by a boolean op |
| fieldMask | input | 8 | Nibble enables for the masked move |
| sumOvf | input | 1 | Summary-overflow flag copied by compares |
| crOut | output | 32 | Current condition register |
| readData | output | 32 | Value captured by the last read-out |

## Verification
The embedded properties assume that `opCode` is always a known value and that the selectors and operands are stable around the rising edge. Under that assumption, the previous-cycle selector values identify which field or bit an operation may touch. The bench changes every input only on the falling edge and always drives defined values. It also drives unrelated selector inputs with nonzero values during compares, copies, reads and idle cycles, so any stray write would show up in the results.

// File: rtl/crl_pkg.sv
package crl_pkg;
  parameter int CR_W  = 32;
  parameter int FLD_W = 4;
  parameter int IMM_W = 16;
  localparam int NUM_FLD = CR_W / FLD_W;
  localparam int FSEL_W  = $clog2(NUM_FLD);
  localparam int IDX_W   = $clog2(CR_W);

  typedef enum logic [3:0] {
    OP_IDLE   = 4'd0,
    OP_CMPS   = 4'd1,
    OP_CMPU   = 4'd2,
    OP_CMPSI  = 4'd3,
    OP_CMPUI  = 4'd4,
    OP_FCOPY  = 4'd5,
    OP_MMOVE  = 4'd6,
    OP_READ   = 4'd7,
    OP_BAND   = 4'd8,
    OP_BOR    = 4'd9,
    OP_BNAND  = 4'd10,
    OP_BXOR   = 4'd11,
    OP_BNOR   = 4'd12,
    OP_BEQV   = 4'd13,
    OP_BANDC  = 4'd14,
    OP_BORC   = 4'd15
  } crOpE;

  typedef enum logic [2:0] {
    FN_AND = 3'd0, FN_OR = 3'd1, FN_NAND = 3'd2, FN_XOR = 3'd3,
    FN_NOR = 3'd4, FN_EQV = 3'd5, FN_ANDC = 3'd6, FN_ORC = 3'd7
  } boolFnE;

  typedef struct packed {
    logic   doCmp;
    logic   cmpSigned;
    logic   cmpImm;
    logic   doBool;
    boolFnE boolFn;
    logic   doCopy;
    logic   doMove;
    logic   doRead;
  } crStrobeS;
endpackage

// File: rtl/crl_ctrl.sv
module crl_ctrl
  import crl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] opCode,
  output crStrobeS   strobe
);
  always_comb begin
    strobe = '0;
    strobe.boolFn = boolFnE'(opCode[2:0]);
    if (opCode[3]) begin
      strobe.doBool = 1'b1;
    end else begin
      case (opCode)
        OP_CMPS:  begin strobe.doCmp = 1'b1; strobe.cmpSigned = 1'b1; end
        OP_CMPU:  strobe.doCmp = 1'b1;
        OP_CMPSI: begin strobe.doCmp = 1'b1; strobe.cmpSigned = 1'b1; strobe.cmpImm = 1'b1; end
        OP_CMPUI: begin strobe.doCmp = 1'b1; strobe.cmpImm = 1'b1; end
        OP_FCOPY: strobe.doCopy = 1'b1;
        OP_MMOVE: strobe.doMove = 1'b1;
        OP_READ:  strobe.doRead = 1'b1;
        default:  ;
      endcase
    end
  end

  // R2 R6 R7 R8 R9: at most one operation class is active per cycle
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doCmp, strobe.doBool, strobe.doCopy, strobe.doMove, strobe.doRead}));
endmodule

// File: rtl/crl_dpath.sv
module crl_dpath
  import crl_pkg::*;
#(
  parameter int DW = CR_W,
  parameter int IW = IMM_W,
  localparam int NF = DW / FLD_W,
  localparam int FW = $clog2(NF),
  localparam int BW = $clog2(DW)
)(
  input  logic          clk,
  input  logic          rstN,
  input  crStrobeS      strobe,
  input  logic [DW-1:0] srcA,
  input  logic [DW-1:0] srcB,
  input  logic [IW-1:0] imm,
  input  logic [FW-1:0] dstField,
  input  logic [FW-1:0] srcField,
  input  logic [BW-1:0] bitA,
  input  logic [BW-1:0] bitB,
  input  logic [BW-1:0] bitT,
  input  logic [NF-1:0] fieldMask,
  input  logic          sumOvf,
  output logic [DW-1:0] crQ,
  output logic [DW-1:0] rdQ
);
  function automatic logic [FLD_W-1:0] nibAt(logic [DW-1:0] v, logic [FW-1:0] f);
    return v[DW-1-FLD_W*f -: FLD_W];
  endfunction

  logic [DW-1:0]    opB, crNext, moveBits;
  logic             isLt, isEq, isGt;
  logic [FLD_W-1:0] cmpNib, wrNib;
  logic [BW-1:0]    posA, posB, posT;
  logic             boolRes;

  // compare
  always_comb begin
    if (!strobe.cmpImm)        opB = srcB;
    else if (strobe.cmpSigned) opB = {{(DW-IW){imm[IW-1]}}, imm};
    else                       opB = {{(DW-IW){1'b0}}, imm};
    isEq = (srcA == opB);
    isLt = strobe.cmpSigned ? ($signed(srcA) < $signed(opB)) : (srcA < opB);
    isGt = !isLt && !isEq;
    cmpNib = {isLt, isGt, isEq, sumOvf};
  end

  // boolean bit op
  always_comb begin
    posA = BW'(DW-1) - bitA;
    posB = BW'(DW-1) - bitB;
    posT = BW'(DW-1) - bitT;
    case (strobe.boolFn)
      FN_AND:  boolRes = crQ[posA] & crQ[posB];
      FN_OR:   boolRes = crQ[posA] | crQ[posB];
      FN_NAND: boolRes = ~(crQ[posA] & crQ[posB]);
      FN_XOR:  boolRes = crQ[posA] ^ crQ[posB];
      FN_NOR:  boolRes = ~(crQ[posA] | crQ[posB]);
      FN_EQV:  boolRes = ~(crQ[posA] ^ crQ[posB]);
      FN_ANDC: boolRes = crQ[posA] & ~crQ[posB];
      default: boolRes = crQ[posA] | ~crQ[posB];
    endcase
  end

  // mask expansion
  for (genvar i = 0; i < NF; i++) begin : g_mask
    assign moveBits[FLD_W*i +: FLD_W] = {FLD_W{fieldMask[i]}};
  end

  // next-state select
  always_comb begin
    crNext = crQ;
    wrNib  = strobe.doCopy ? nibAt(crQ, srcField) : cmpNib;
    if (strobe.doCmp || strobe.doCopy) begin
      for (int f = 0; f < NF; f++) begin
        if (dstField == FW'(f)) crNext[DW-1-FLD_W*f -: FLD_W] = wrNib;
      end
    end else if (strobe.doBool) begin
      crNext[posT] = boolRes;
    end else if (strobe.doMove) begin
      crNext = (srcA & moveBits) | (crQ & ~moveBits);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      crQ <= '0;
      rdQ <= '0;
    end else begin
      crQ <= crNext;
      if (strobe.doRead) rdQ <= crQ;
    end
  end

  // R2
  cmp_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCmp |=> $countones(nibAt(crQ, $past(dstField)) & 4'hE) == 1);
  // R5
  cmp_so_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCmp |=> (nibAt(crQ, $past(dstField)) & 4'h1) == {3'b000, $past(sumOvf)});
  // R6
  bool_single_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doBool |=> ((crQ ^ $past(crQ)) & ~({{(DW-1){1'b0}}, 1'b1} << (DW-1-$past(bitT)))) == '0);
  // R8
  move_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doMove |=> ((crQ ^ $past(crQ)) & ~$past(moveBits)) == '0);
  // R9
  read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doRead |=> (rdQ == $past(crQ)) && $stable(crQ));
  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == crStrobeS'({strobe.boolFn, 4'b0} << 4)) |=> $stable(crQ) && $stable(rdQ));
endmodule

// File: rtl/crl_unit.sv
module crl_unit
  import crl_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  opCode,
  input  logic [31:0] srcA,
  input  logic [31:0] srcB,
  input  logic [15:0] imm16,
  input  logic [2:0]  dstField,
  input  logic [2:0]  srcField,
  input  logic [4:0]  bitA,
  input  logic [4:0]  bitB,
  input  logic [4:0]  bitT,
  input  logic [7:0]  fieldMask,
  input  logic        sumOvf,
  output logic [31:0] crOut,
  output logic [31:0] readData
);
  crStrobeS strobe;

  crl_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opCode(opCode), .strobe(strobe)
  );

  crl_dpath #(.DW(32), .IW(16)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcA(srcA), .srcB(srcB), .imm(imm16),
    .dstField(dstField), .srcField(srcField),
    .bitA(bitA), .bitB(bitB), .bitT(bitT),
    .fieldMask(fieldMask), .sumOvf(sumOvf),
    .crQ(crOut), .rdQ(readData)
  );
endmodule

// File: tb/sim_crl_unit.sv
module sim_crl_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [31:0] srcA = '0, srcB = '0;
  logic [15:0] imm16 = '0;
  logic [2:0]  dstField = '0, srcField = '0;
  logic [4:0]  bitA = '0, bitB = '0, bitT = '0;
  logic [7:0]  fieldMask = '0;
  logic        sumOvf = 1'b0;
  logic [31:0] crOut, readData;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] mCr = '0, mRd = '0;

  always #10 clk = ~clk;

  crl_unit u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] cmpModel(input bit sgn, input logic [31:0] a, input logic [31:0] b, input bit so);
    logic lt;
    lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
    if (a == b) return {3'b001, so};
    return lt ? {3'b100, so} : {3'b010, so};
  endfunction

  task automatic runCmp(input string req, input logic [3:0] op, input logic [31:0] a,
                        input logic [31:0] b, input logic [15:0] im, input logic [2:0] f, input bit so);
    logic [31:0] other;
    bit sgn;
    sgn = (op == 4'd1) || (op == 4'd3);
    if (op >= 4'd3) other = sgn ? {{16{im[15]}}, im} : {16'h0, im};
    else other = b;
    opCode = op; srcA = a; srcB = b; imm16 = im; dstField = f; sumOvf = so;
    srcField = ~f; bitT = 5'd17; fieldMask = 8'hFF;
    mCr[31-4*f -: 4] = cmpModel(sgn, a, other, so);
    step();
    chk(req, crOut, mCr);
  endtask

  task automatic testReset();
    chk("R1", crOut, 32'h0);
    chk("R1", readData, 32'h0);
  endtask

  task automatic testCompares();
    runCmp("R2", 4'd1, 32'hFFFF_FFFB, 32'd3, 16'h0, 3'd0, 1'b0);
    runCmp("R3", 4'd2, 32'hFFFF_FFFB, 32'd3, 16'h0, 3'd1, 1'b0);
    runCmp("R2", 4'd1, 32'h1234, 32'h1234, 16'h0, 3'd7, 1'b1);
    runCmp("R3", 4'd2, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 3'd6, 1'b0);
    runCmp("R2", 4'd1, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 3'd5, 1'b0);
    runCmp("R4", 4'd3, 32'h0, 32'h0, 16'hFFFF, 3'd2, 1'b0);
    runCmp("R4", 4'd4, 32'h0, 32'h0, 16'hFFFF, 3'd3, 1'b0);
    runCmp("R4", 4'd4, 32'h0000_FFFF, 32'h0, 16'hFFFF, 3'd4, 1'b1);
    runCmp("R4", 4'd3, 32'h0000_FFFF, 32'h0, 16'hFFFF, 3'd4, 1'b0);
    runCmp("R5", 4'd2, 32'd9, 32'd2, 16'h0, 3'd0, 1'b1);
    chk("R5", {28'h0, crOut[28]} , 32'h1);
  endtask

  task automatic testBool();
    for (int k = 0; k < 8; k++) begin
      for (int p = 0; p < 4; p++) begin
        logic a, b, r;
        logic [4:0] ia, ib, it;
        ia = 5'(3 + 7 * k + p) ;
        ib = 5'(11 + 5 * k + 2 * p);
        it = 5'(29 - 3 * k - p);
        a = mCr[31 - ia]; b = mCr[31 - ib];
        case (k)
          0: r = a & b;       1: r = a | b;
          2: r = ~(a & b);    3: r = a ^ b;
          4: r = ~(a | b);    5: r = ~(a ^ b);
          6: r = a & ~b;      default: r = a | ~b;
        endcase
        opCode = 4'(8 + k); bitA = ia; bitB = ib; bitT = it;
        dstField = 3'd5; srcField = 3'd2; fieldMask = 8'hFF; srcA = 32'hFFFF_FFFF;
        mCr[31 - it] = r;
        step();
        chk("R6", crOut, mCr);
      end
    end
  endtask

  task automatic testCopy();
    opCode = 4'd5; srcField = 3'd0; dstField = 3'd5; bitT = 5'd0; fieldMask = 8'hFF;
    mCr[31-4*5 -: 4] = mCr[31 -: 4];
    step();
    chk("R7", crOut, mCr);
    srcField = 3'd3; dstField = 3'd3;
    step();
    chk("R7", crOut, mCr);
    srcField = 3'd7; dstField = 3'd1;
    mCr[31-4*1 -: 4] = mCr[31-4*7 -: 4];
    step();
    chk("R7", crOut, mCr);
  endtask

  task automatic testMove();
    opCode = 4'd6; srcA = 32'hA5C3_96E1; fieldMask = 8'h81; dstField = 3'd2; bitT = 5'd4;
    mCr = {srcA[31:28], mCr[27:4], srcA[3:0]};
    step();
    chk("R8", crOut, mCr);
    fieldMask = 8'h00; srcA = 32'h1234_5678;
    step();
    chk("R8", crOut, mCr);
    fieldMask = 8'h3C;
    mCr = {mCr[31:24], srcA[23:8], mCr[7:0]};
    step();
    chk("R8", crOut, mCr);
  endtask

  task automatic testReadIdle();
    opCode = 4'd7; srcA = 32'hDEAD_BEEF; fieldMask = 8'hFF; dstField = 3'd4;
    mRd = mCr;
    step();
    chk("R9", readData, mRd);
    chk("R9", crOut, mCr);
    opCode = 4'd2; srcA = 32'd1; srcB = 32'd2; dstField = 3'd6; sumOvf = 1'b0;
    mCr[31-4*6 -: 4] = 4'h8;
    step();
    chk("R9", readData, mRd);
    opCode = 4'd0; srcA = 32'hFFFF_FFFF; srcB = 32'h0; fieldMask = 8'hFF;
    bitT = 5'd9; dstField = 3'd0; srcField = 3'd6; sumOvf = 1'b1;
    step();
    step();
    chk("R10", crOut, mCr);
    chk("R10", readData, mRd);
    opCode = 4'd7;
    mRd = mCr;
    step();
    chk("R9", readData, mRd);
  endtask

  task automatic testResetAgain();
    rstN = 1'b0; opCode = 4'd6; fieldMask = 8'hFF; srcA = 32'hFFFF_FFFF;
    step();
    chk("R1", crOut, 32'h0);
    chk("R1", readData, 32'h0);
    rstN = 1'b1; opCode = 4'd0;
    mCr = '0; mRd = '0;
    step();
    chk("R1", crOut, 32'h0);
  endtask

  initial begin
    step();
    step();
    testReset();
    rstN = 1'b1;
    step();
    testReset();
    testCompares();
    testBool();
    testCopy();
    testMove();
    testReadIdle();
    testResetAgain();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule